// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit with Status Flags

This block is the data path core of a small accumulator-centred processor. It holds the 8-bit accumulator, the five status flags and a 16-bit pair result. On each cycle in which a request is presented, it combines the accumulator with one second operand and writes the result back into the accumulator. The second operand is chosen from three byte buses: an immediate byte, a general register byte, or a byte that the surrounding core has already fetched from memory.

The operations are add, add with carry, subtract, subtract with borrow, unsigned compare, AND, XOR, OR, complement, load, and a 16-bit add of two register pairs. The 16-bit add of a pair to itself is a one-bit left shift. Decoding, fetch and memory access stay in the surrounding core. All results are registered, so an operation presented before a rising edge is visible on the outputs right after that edge.

Top module: `acc_alu`

## Requirements
- R1: While `rst` is high at a rising edge, `acc_q`, `flags_q` and `pair_q` become zero.
- R2: The second operand is `imm_byte` when `src_sel` is 0 or 3, `reg_byte` when `src_sel` is 1, and `mem_byte` when `src_sel` is 2.
- R3: Code 1 (add) and code 2 (add with carry) load the accumulator with the accumulator plus the operand, plus the carry flag for code 2, modulo 256. Carry is set to the carry out of bit 7. Auxiliary carry is set to the carry out of bit 3.
- R4: Code 3 (subtract) and code 4 (subtract with borrow) load the accumulator with the accumulator minus the operand, minus the carry flag for code 4, modulo 256. Carry is set to 1 when a borrow occurs. Auxiliary carry is set to the carry out of bit 3 of the sum of the accumulator, the inverted operand, and one minus the borrow in.
- R5: Code 5 (compare) sets all five flags as code 3 does and leaves the accumulator unchanged.
- R6: Code 6 is AND, code 7 is XOR and code 8 is OR. Each applies the bitwise operation to the accumulator and the operand, writes the result to the accumulator, and clears both carry and auxiliary carry.
- R7: `flags_q` bit 0 is carry, bit 1 is parity, bit 2 is auxiliary carry, bit 3 is zero and bit 4 is sign. After codes 1 to 8, sign is bit 7 of the result, zero is 1 when the result is 0, and parity is 1 when the result has an even number of one bits.
- R8: Code 9 inverts every bit of the accumulator and changes no flag.
- R9: Code 10 copies the operand into the accumulator and changes no flag.
- R10: Code 0, codes 12 to 15, and any cycle with `op_valid` low change no output.
- R11: Code 11 loads `pair_q` with `pair_a` plus `pair_b` modulo 65536 and sets carry to the carry out of bit 15. The other four flags and the accumulator are unchanged. Equal pair inputs therefore give a one-bit left shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation request for this cycle |
| op_code | input | 4 | Operation class code |
| src_sel | input | 2 | Second operand source select |
| imm_byte | input | 8 | Immediate operand |
| reg_byte | input | 8 | General register operand |
| mem_byte | input | 8 | Operand fetched from memory |
| pair_a | input | 16 | First register pair for the 16-bit add |
| pair_b | input | 16 | Second register pair for the 16-bit add |
| acc_q | output | 8 | Accumulator |
| flags_q | output | 5 | Flags {sign, zero, aux carry, parity, carry} |
| pair_q | output | 16 | Result of the last 16-bit pair add |

## Verification
The assertions assume that `op_code` and `op_valid` carry known values at every clock edge once reset has been released. They also assume that each request is held for exactly one edge, so each post-edge check refers to exactly one operation. The stimulus drives every input away from the clock edge and keeps `op_valid` a known 0 or 1. It draws opcodes from the full 4-bit range, so the spare codes are included. All three operand buses and the source select are randomised together, so that a wrong source selection changes the result.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int FLAG_N = 5;
  localparam int FLG_CY = 0;
  localparam int FLG_P  = 1;
  localparam int FLG_AC = 2;
  localparam int FLG_Z  = 3;
  localparam int FLG_S  = 4;

  typedef enum logic [3:0] {
    OP_NOP  = 4'd0,
    OP_ADD  = 4'd1,
    OP_ADC  = 4'd2,
    OP_SUB  = 4'd3,
    OP_SBB  = 4'd4,
    OP_CMP  = 4'd5,
    OP_AND  = 4'd6,
    OP_XOR  = 4'd7,
    OP_OR   = 4'd8,
    OP_CMA  = 4'd9,
    OP_LDA  = 4'd10,
    OP_PADD = 4'd11
  } alu_op_e;

  typedef enum logic [1:0] {
    LOP_AND = 2'd0,
    LOP_XOR = 2'd1,
    LOP_OR  = 2'd2
  } logic_op_e;

  typedef enum logic [1:0] {
    SRC_IMM = 2'd0,
    SRC_REG = 2'd1,
    SRC_MEM = 2'd2
  } src_e;

endpackage

// File: rtl/acc_alu_opsel.sv
module acc_alu_opsel #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        src_sel,
  input  logic [DATA_W-1:0] imm_byte,
  input  logic [DATA_W-1:0] reg_byte,
  input  logic [DATA_W-1:0] mem_byte,
  output logic [DATA_W-1:0] operand
);
  import acc_alu_pkg::*;

  always_comb begin
    case (src_e'(src_sel))
      SRC_REG: operand = reg_byte;
      SRC_MEM: operand = mem_byte;
      default: operand = imm_byte;
    endcase
  end
endmodule

// File: rtl/acc_alu_arith.sv
module acc_alu_arith #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  input  logic              sub,
  input  logic              carry_in,
  output logic [DATA_W-1:0] result,
  output logic              carry_out,
  output logic              aux_out
);
  localparam int LO_W = DATA_W / 2;
  localparam int HI_W = DATA_W - LO_W;

  logic [DATA_W-1:0] b_eff;
  logic              c0;
  logic [LO_W:0]     lo_sum;
  logic [HI_W:0]     hi_sum;

  always_comb begin
    b_eff  = sub ? ~b : b;
    c0     = sub ? ~carry_in : carry_in;
    lo_sum = {1'b0, a[LO_W-1:0]} + {1'b0, b_eff[LO_W-1:0]} + {{LO_W{1'b0}}, c0};
    hi_sum = {1'b0, a[DATA_W-1:LO_W]} + {1'b0, b_eff[DATA_W-1:LO_W]}
           + {{HI_W{1'b0}}, lo_sum[LO_W]};
    result    = {hi_sum[HI_W-1:0], lo_sum[LO_W-1:0]};
    aux_out   = lo_sum[LO_W];
    carry_out = sub ? ~hi_sum[HI_W] : hi_sum[HI_W];
  end
endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic #(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        lop,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] result
);
  import acc_alu_pkg::*;

  always_comb begin
    case (logic_op_e'(lop))
      LOP_XOR: result = a ^ b;
      LOP_OR:  result = a | b;
      default: result = a & b;
    endcase
  end
endmodule

// File: rtl/acc_alu_pair_add.sv
module acc_alu_pair_add #(
  parameter int PAIR_W = 16
) (
  input  logic [PAIR_W-1:0] a,
  input  logic [PAIR_W-1:0] b,
  output logic [PAIR_W-1:0] sum,
  output logic              carry_out
);
  logic [PAIR_W:0] full;

  always_comb begin
    full      = {1'b0, a} + {1'b0, b};
    sum       = full[PAIR_W-1:0];
    carry_out = full[PAIR_W];
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int DATA_W = 8,
  parameter int PAIR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [1:0]        src_sel,
  input  logic [DATA_W-1:0] imm_byte,
  input  logic [DATA_W-1:0] reg_byte,
  input  logic [DATA_W-1:0] mem_byte,
  input  logic [PAIR_W-1:0] pair_a,
  input  logic [PAIR_W-1:0] pair_b,
  output logic [DATA_W-1:0] acc_q,
  output logic [4:0]        flags_q,
  output logic [PAIR_W-1:0] pair_q
);
  import acc_alu_pkg::*;

  alu_op_e           op;
  logic [DATA_W-1:0] operand;
  logic [DATA_W-1:0] arith_res;
  logic [DATA_W-1:0] logic_res;
  logic [PAIR_W-1:0] pair_sum;
  logic              arith_cy;
  logic              arith_ac;
  logic              pair_cy;
  logic              is_sub;
  logic              use_cy;
  logic [1:0]        lop;
  logic [DATA_W-1:0] acc_d;
  logic [4:0]        flg_d;
  logic [PAIR_W-1:0] pair_d;
  logic [DATA_W-1:0] res;

  assign op     = alu_op_e'(op_code);
  assign is_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_CMP);
  assign use_cy = (op == OP_ADC) || (op == OP_SBB);

  always_comb begin
    case (op)
      OP_XOR:  lop = LOP_XOR;
      OP_OR:   lop = LOP_OR;
      default: lop = LOP_AND;
    endcase
  end

  acc_alu_opsel #(.DATA_W(DATA_W)) i_opsel (
    .src_sel (src_sel),
    .imm_byte(imm_byte),
    .reg_byte(reg_byte),
    .mem_byte(mem_byte),
    .operand (operand)
  );

  acc_alu_arith #(.DATA_W(DATA_W)) i_arith (
    .a        (acc_q),
    .b        (operand),
    .sub      (is_sub),
    .carry_in (use_cy & flags_q[FLG_CY]),
    .result   (arith_res),
    .carry_out(arith_cy),
    .aux_out  (arith_ac)
  );

  acc_alu_logic #(.DATA_W(DATA_W)) i_logic (
    .lop   (lop),
    .a     (acc_q),
    .b     (operand),
    .result(logic_res)
  );

  acc_alu_pair_add #(.PAIR_W(PAIR_W)) i_pair (
    .a        (pair_a),
    .b        (pair_b),
    .sum      (pair_sum),
    .carry_out(pair_cy)
  );

  always_comb begin
    acc_d  = acc_q;
    flg_d  = flags_q;
    pair_d = pair_q;
    res    = arith_res;
    if (op_valid) begin
      case (op)
        OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_CMP: begin
          res           = arith_res;
          flg_d[FLG_CY] = arith_cy;
          flg_d[FLG_AC] = arith_ac;
          flg_d[FLG_S]  = res[DATA_W-1];
          flg_d[FLG_Z]  = (res == '0);
          flg_d[FLG_P]  = ~(^res);
          if (op != OP_CMP) acc_d = res;
        end
        OP_AND, OP_XOR, OP_OR: begin
          res           = logic_res;
          acc_d         = res;
          flg_d[FLG_CY] = 1'b0;
          flg_d[FLG_AC] = 1'b0;
          flg_d[FLG_S]  = res[DATA_W-1];
          flg_d[FLG_Z]  = (res == '0);
          flg_d[FLG_P]  = ~(^res);
        end
        OP_CMA: acc_d = ~acc_q;
        OP_LDA: acc_d = operand;
        OP_PADD: begin
          pair_d        = pair_sum;
          flg_d[FLG_CY] = pair_cy;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      flags_q <= '0;
      pair_q  <= '0;
    end else begin
      acc_q   <= acc_d;
      flags_q <= flg_d;
      pair_q  <= pair_d;
    end
  end

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!op_valid || op_code == 4'd0 || op_code >= 4'd12)
    |=> ($stable(acc_q) && $stable(flags_q) && $stable(pair_q))); // R10

  AST_LOGIC_CARRY_CLR: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == 4'd6 || op_code == 4'd7 || op_code == 4'd8))
    |=> (!flags_q[FLG_CY] && !flags_q[FLG_AC])); // R6

  AST_RESULT_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code >= 4'd1 && op_code <= 4'd8 && op_code != 4'd5)
    |=> (flags_q[FLG_Z] == (acc_q == '0) && flags_q[FLG_S] == acc_q[DATA_W-1]
         && flags_q[FLG_P] == ($countones(acc_q) % 2 == 0))); // R7

  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd5) |=> $stable(acc_q)); // R5

  AST_CMA_INVERT: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd9)
    |=> (acc_q == ~$past(acc_q) && $stable(flags_q))); // R8

  AST_LDA_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd10) |=> $stable(flags_q)); // R9

  AST_PAIR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd11)
    |=> ($stable(acc_q) && flags_q[4:1] == $past(flags_q[4:1]))); // R11

  AST_ACC_ONLY_ON_OPS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 4'd11) |=> $stable(acc_q)); // R11
endmodule

// File: tb/test_acc_alu.sv
`timescale 1ns/1ps
module test_acc_alu;
  logic        clk = 1'b0;
  logic        rst;
  logic        op_valid;
  logic [3:0]  op_code;
  logic [1:0]  src_sel;
  logic [7:0]  imm_byte, reg_byte, mem_byte;
  logic [15:0] pair_a, pair_b;
  logic [7:0]  acc_q;
  logic [4:0]  flags_q;
  logic [15:0] pair_q;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [7:0]  m_acc;
  logic [4:0]  m_flg;
  logic [15:0] m_pair;

  always #2.5 clk = ~clk;

  acc_alu i_acc_alu (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
    .src_sel(src_sel), .imm_byte(imm_byte), .reg_byte(reg_byte),
    .mem_byte(mem_byte), .pair_a(pair_a), .pair_b(pair_b),
    .acc_q(acc_q), .flags_q(flags_q), .pair_q(pair_q)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pick(input logic [1:0] s, input logic [7:0] i,
                                      input logic [7:0] r, input logic [7:0] m);
    if (s == 2'd1) return r;
    if (s == 2'd2) return m;
    return i;
  endfunction

  function automatic logic [4:0] szp(input logic [4:0] f, input logic [7:0] v);
    logic [4:0] o;
    o = f;
    o[4] = v[7];
    o[3] = (v == 8'd0);
    o[1] = ($countones(v) % 2 == 0);
    return o;
  endfunction

  // Reference model from R2..R11
  task automatic model(input bit v, input logic [3:0] op, input logic [7:0] b,
                       input logic [15:0] pa, input logic [15:0] pb);
    int s, cin, d;
    logic [7:0] r;
    if (!v) return;
    case (op)
      4'd1, 4'd2: begin // R3
        cin = (op == 4'd2) ? int'(m_flg[0]) : 0;
        s = int'(m_acc) + int'(b) + cin;
        r = s[7:0];
        m_flg = szp(m_flg, r);
        m_flg[0] = (s > 255);
        m_flg[2] = ((int'(m_acc & 8'hF) + int'(b & 8'hF) + cin) > 15);
        m_acc = r;
      end
      4'd3, 4'd4, 4'd5: begin // R4 R5
        cin = (op == 4'd4) ? int'(m_flg[0]) : 0;
        d = int'(m_acc) - int'(b) - cin;
        r = d[7:0];
        m_flg = szp(m_flg, r);
        m_flg[0] = (d < 0);
        m_flg[2] = ((int'(m_acc & 8'hF) + int'((~b) & 8'hF) + 1 - cin) > 15);
        if (op != 4'd5) m_acc = r;
      end
      4'd6, 4'd7, 4'd8: begin // R6
        r = (op == 4'd6) ? (m_acc & b) : (op == 4'd7) ? (m_acc ^ b) : (m_acc | b);
        m_flg = szp(m_flg, r);
        m_flg[0] = 1'b0;
        m_flg[2] = 1'b0;
        m_acc = r;
      end
      4'd9:  m_acc = ~m_acc;  // R8
      4'd10: m_acc = b;       // R9
      4'd11: begin            // R11
        s = int'(pa) + int'(pb);
        m_pair = s[15:0];
        m_flg[0] = (s > 65535);
      end
      default: ; // R10
    endcase
  endtask

  task automatic run_op(input string req, input bit v, input logic [3:0] op,
                        input logic [1:0] sel, input logic [7:0] i, input logic [7:0] r,
                        input logic [7:0] m, input logic [15:0] pa, input logic [15:0] pb);
    @(negedge clk);
    op_valid = v; op_code = op; src_sel = sel;
    imm_byte = i; reg_byte = r; mem_byte = m; pair_a = pa; pair_b = pb;
    model(v, op, pick(sel, i, r, m), pa, pb);
    @(negedge clk);
    op_valid = 1'b0;
    check({req, " acc"}, 32'(acc_q), 32'(m_acc));
    check({req, " flags"}, 32'(flags_q), 32'(m_flg));
    check({req, " pair"}, 32'(pair_q), 32'(m_pair));
  endtask

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; op_valid = 1'b0; op_code = '0; src_sel = '0;
    imm_byte = '0; reg_byte = '0; mem_byte = '0; pair_a = '0; pair_b = '0;
    m_acc = '0; m_flg = '0; m_pair = '0;
    // R1: preload something then reset
    repeat (3) @(negedge clk);
    rst = 1'b0;
    run_op("R9 load", 1, 4'd10, 2'd0, 8'h5A, 8'h00, 8'h00, 16'h0, 16'h0);
    run_op("R11 pair", 1, 4'd11, 2'd0, 8'h00, 8'h00, 8'h00, 16'h1234, 16'h1111);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    m_acc = '0; m_flg = '0; m_pair = '0;
    check("R1 acc", 32'(acc_q), 32'h0);
    check("R1 flags", 32'(flags_q), 32'h0);
    check("R1 pair", 32'(pair_q), 32'h0);
    // R2 operand sources through load
    run_op("R2 reg", 1, 4'd10, 2'd1, 8'h11, 8'h22, 8'h33, 16'h0, 16'h0);
    run_op("R2 mem", 1, 4'd10, 2'd2, 8'h11, 8'h22, 8'h33, 16'h0, 16'h0);
    run_op("R2 sel3", 1, 4'd10, 2'd3, 8'h11, 8'h22, 8'h33, 16'h0, 16'h0);
    // R3 aux carry and wrap
    run_op("R9 set", 1, 4'd10, 2'd0, 8'h0F, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R3 aux", 1, 4'd1, 2'd0, 8'h01, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R9 set", 1, 4'd10, 2'd0, 8'hFF, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R3 wrap", 1, 4'd1, 2'd1, 8'h0, 8'h01, 8'h0, 16'h0, 16'h0);
    run_op("R3 adc", 1, 4'd2, 2'd2, 8'h0, 8'h0, 8'h7F, 16'h0, 16'h0);
    // R4 borrow
    run_op("R9 set", 1, 4'd10, 2'd0, 8'h00, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R4 borrow", 1, 4'd3, 2'd0, 8'h01, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R4 sbb", 1, 4'd4, 2'd0, 8'h10, 8'h0, 8'h0, 16'h0, 16'h0);
    // R5 compare equal
    run_op("R5 cmp", 1, 4'd5, 2'd0, 8'hEE, 8'h0, 8'h0, 16'h0, 16'h0);
    // R6 logic clears carry
    run_op("R6 and", 1, 4'd6, 2'd0, 8'h0F, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R6 xor", 1, 4'd7, 2'd0, 8'h0F, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R6 or", 1, 4'd8, 2'd0, 8'h81, 8'h0, 8'h0, 16'h0, 16'h0);
    // R7 parity on even count, R8 complement
    run_op("R7 parity", 1, 4'd7, 2'd0, 8'hFF, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R8 cma", 1, 4'd9, 2'd0, 8'h00, 8'h0, 8'h0, 16'h0, 16'h0);
    // R10 idle, nop, spare code
    run_op("R10 idle", 0, 4'd1, 2'd0, 8'h55, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R10 nop", 1, 4'd0, 2'd0, 8'h55, 8'h0, 8'h0, 16'h0, 16'h0);
    run_op("R10 spare", 1, 4'd14, 2'd0, 8'h55, 8'h0, 8'h0, 16'hFFFF, 16'h1);
    // R11 left shift by self add
    run_op("R11 shift", 1, 4'd11, 2'd0, 8'h0, 8'h0, 8'h0, 16'h8001, 16'h8001);
    run_op("R11 nocarry", 1, 4'd11, 2'd0, 8'h0, 8'h0, 8'h0, 16'h2345, 16'h2345);
    // Random mix covering R2..R11
    for (int k = 0; k < 3000; k++) begin
      run_op("R2-mix", ($urandom_range(0, 7) != 0), 4'($urandom_range(0, 15)),
             2'($urandom_range(0, 3)), 8'($urandom), 8'($urandom), 8'($urandom),
             16'($urandom), 16'($urandom));
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule